// File: doc/BRIEF.md
# Unsigned Integer to Double Converter

This block turns one unsigned integer into an IEEE-754 binary64 value and places it in the low 64-bit lane of a vector result. The integer is read as 32 or 64 bits wide, chosen by a width select. The high 64-bit lane of the result is copied from a pass-through vector operand. Every bit above bit 127, up to a configurable maximum vector length, is zero.

A conversion that cannot be exact is rounded and raises an inexact flag. The rounding mode normally comes from a global field. A per-operation override takes its place only when three things hold: the integer arrives from a register, the override is enabled, and the 64-bit width is selected.

The datapath has one register stage. An operand accepted with `in_valid` appears at the outputs with `out_valid` one clock later.

Top module: `u2d_convert_top`

## Requirements
- R1: When `wide_sel` is 1, all 64 bits of `int_src` are converted. When it is 0, only `int_src[31:0]` is converted, as an unsigned value, and bits 63:32 have no effect on the result.
- R2: `result[63:0]` holds the binary64 encoding. The sign bit is always 0, the exponent is 1023 plus the index of the most significant set bit, and a zero input gives all-zero bits with no inexact flag.
- R3: `result[127:64]` equals `vec_src[127:64]` of the same operation.
- R4: `result` bits from 128 to MAXVL-1 are always zero.
- R5: The rounding modes are encoded 00 round-to-nearest-even, 01 toward negative infinity, 10 toward positive infinity and 11 toward zero. Modes 01 and 11 truncate, mode 10 rounds up any nonzero remainder, and mode 00 rounds up above half and rounds ties to an even significand. A carry out of the significand raises the exponent by one and clears the fraction.
- R6: The applied mode is `ovr_rm` when `src_is_reg`, `ovr_en` and `wide_sel` are all 1, and `glob_rm` otherwise.
- R7: When `wide_sel` is 0, the values of `ovr_en` and `ovr_rm` have no effect on the result.
- R8: `inexact` is 1 exactly when the discarded low bits of the converted value are nonzero. It is never 1 when `wide_sel` is 0.
- R9: `out_valid` is 1 in the cycle after a cycle with `in_valid` high and 0 otherwise. Result and flag hold their last values while `in_valid` is low.
- R10: After a synchronous reset, `out_valid`, `result` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand accepted this cycle |
| int_src | input | 64 | Unsigned integer operand |
| wide_sel | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| vec_src | input | 128 | Pass-through vector operand |
| glob_rm | input | 2 | Global rounding mode |
| ovr_en | input | 1 | Per-operation rounding override enable |
| ovr_rm | input | 2 | Per-operation rounding mode |
| src_is_reg | input | 1 | 1 = operand from a register, 0 = from memory |
| out_valid | output | 1 | Result valid |
| result | output | MAXVL | Merged vector result |
| inexact | output | 1 | Precision flag |

## Verification
The assertions assume that every input is at a known level whenever `in_valid` is high, and that reset is held for at least one clock edge before any operand is presented. The bench changes inputs only on falling edges and pulses `in_valid` one operand at a time, so each sampled operand is stable. Ties, carries out of the significand, the largest 64-bit value and masked upper 32 bits are all driven explicitly. They are not left to the pseudo-random sweep.

// File: rtl/u2d_pkg.sv
package u2d_pkg;
  localparam int INT_W  = 64;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int BIAS   = 1023;
  localparam int LANE_W = 64;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int DROP_W = INT_W - SIG_W;
  localparam int CNT_W  = $clog2(INT_W) + 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/u2d_rmode_sel.sv
module u2d_rmode_sel
  import u2d_pkg::*;
(
  input  logic [1:0] glob_rm,
  input  logic       ovr_en,
  input  logic [1:0] ovr_rm,
  input  logic       src_is_reg,
  input  logic       wide_sel,
  output rmode_e     rm
);
  logic use_ovr;
  always_comb begin
    use_ovr = src_is_reg & ovr_en & wide_sel;
    rm      = use_ovr ? rmode_e'(ovr_rm) : rmode_e'(glob_rm);
  end
endmodule

// File: rtl/u2d_lzc.sv
module u2d_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] count,
  output logic          all_zero
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && val[i]) begin
        count = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
    all_zero = ~found;
  end
endmodule

// File: rtl/u2d_normalize.sv
module u2d_normalize
  import u2d_pkg::*;
(
  input  logic [INT_W-1:0] val,
  output logic [INT_W-1:0] norm,
  output logic [EXP_W-1:0] exp_base,
  output logic             is_zero
);
  logic [CNT_W-1:0] lz;

  u2d_lzc #(.W(INT_W), .CW(CNT_W)) i_lzc (
    .val      (val),
    .count    (lz),
    .all_zero (is_zero)
  );

  always_comb begin
    norm     = val << lz;
    exp_base = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);
  end
endmodule

// File: rtl/u2d_round.sv
module u2d_round
  import u2d_pkg::*;
(
  input  logic [INT_W-1:0] norm,
  input  logic [EXP_W-1:0] exp_base,
  input  logic             is_zero,
  input  rmode_e           rm,
  output logic [LANE_W-1:0] bits,
  output logic             inexact
);
  logic [SIG_W-1:0] sig;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] exp_fin;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sig    = norm[INT_W-1 -: SIG_W];
    guard  = norm[DROP_W-1];
    sticky = |norm[DROP_W-2:0];
    unique case (rm)
      RM_NEAR: inc = guard & (sticky | sig[0]);
      RM_UP:   inc = guard | sticky;
      default: inc = 1'b0;
    endcase
    sum     = {1'b0, sig} + (SIG_W+1)'(inc);
    exp_fin = exp_base + EXP_W'(sum[SIG_W]);
    frac    = sum[SIG_W] ? '0 : sum[FRAC_W-1:0];
    if (is_zero) begin
      bits    = '0;
      inexact = 1'b0;
    end else begin
      bits    = {1'b0, exp_fin, frac};
      inexact = guard | sticky;
    end
  end
endmodule

// File: rtl/u2d_convert_top.sv
module u2d_convert_top
  import u2d_pkg::*;
#(
  parameter int MAXVL = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [63:0]      int_src,
  input  logic             wide_sel,
  input  logic [127:0]     vec_src,
  input  logic [1:0]       glob_rm,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_rm,
  input  logic             src_is_reg,
  output logic             out_valid,
  output logic [MAXVL-1:0] result,
  output logic             inexact
);
  localparam int PAD_W = MAXVL - 2 * LANE_W;

  logic [INT_W-1:0]  operand;
  rmode_e            rm;
  logic [INT_W-1:0]  norm;
  logic [EXP_W-1:0]  exp_base;
  logic              is_zero;
  logic [LANE_W-1:0] conv_bits;
  logic              conv_inexact;

  logic [LANE_W-1:0] lo_q, hi_q;
  logic              ix_q, vld_q;

  always_comb operand = wide_sel ? int_src : {32'b0, int_src[31:0]};

  u2d_rmode_sel i_rsel (
    .glob_rm    (glob_rm),
    .ovr_en     (ovr_en),
    .ovr_rm     (ovr_rm),
    .src_is_reg (src_is_reg),
    .wide_sel   (wide_sel),
    .rm         (rm)
  );

  u2d_normalize i_norm (
    .val      (operand),
    .norm     (norm),
    .exp_base (exp_base),
    .is_zero  (is_zero)
  );

  u2d_round i_rnd (
    .norm     (norm),
    .exp_base (exp_base),
    .is_zero  (is_zero),
    .rm       (rm),
    .bits     (conv_bits),
    .inexact  (conv_inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ix_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        lo_q <= conv_bits;
        hi_q <= vec_src[127:64];
        ix_q <= conv_inexact;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign result = {{PAD_W{1'b0}}, hi_q, lo_q};
    end else begin : g_nopad
      assign result = {hi_q, lo_q};
    end
  endgenerate

  assign out_valid = vld_q;
  assign inexact   = ix_q;
endmodule

// File: rtl/u2d_checker.sv
module u2d_checker #(
  parameter int MAXVL = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [63:0]      int_src,
  input logic             wide_sel,
  input logic [127:0]     vec_src,
  input logic             out_valid,
  input logic [MAXVL-1:0] result,
  input logic             inexact
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    in_valid |=> out_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !in_valid |=> $stable(result) && $stable(inexact));
  assert_lane_copy_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    in_valid |=> result[127:64] == $past(vec_src[127:64]));
  assert_narrow_exact_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && !wide_sel) |=> !inexact);
  assert_zero_in_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && (wide_sel ? (int_src == 64'd0) : (int_src[31:0] == 32'd0)))
      |=> (result[63:0] == 64'd0) && !inexact);
  assert_sign_clear_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !result[63]);

  generate
    if (MAXVL > 128) begin : g_padchk
      assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
        result[MAXVL-1:128] == '0);
    end
  endgenerate
endmodule

bind u2d_convert_top u2d_checker #(.MAXVL(MAXVL)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .int_src   (int_src),
  .wide_sel  (wide_sel),
  .vec_src   (vec_src),
  .out_valid (out_valid),
  .result    (result),
  .inexact   (inexact)
);

// File: tb/test_u2d_convert_top.sv
module test_u2d_convert_top;
  localparam int MAXVL  = 512;
  localparam int CLK_PS = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [63:0]      int_src = '0;
  logic             wide_sel = 1'b0;
  logic [127:0]     vec_src = '0;
  logic [1:0]       glob_rm = '0;
  logic             ovr_en = 1'b0;
  logic [1:0]       ovr_rm = '0;
  logic             src_is_reg = 1'b0;
  logic             out_valid;
  logic [MAXVL-1:0] result;
  logic             inexact;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] exp_lo_q[$];
  logic [63:0] exp_hi_q[$];
  logic        exp_ix_q[$];
  string       tag_q[$];

  always #(CLK_PS/2) clk = ~clk;

  u2d_convert_top #(.MAXVL(MAXVL)) i_u2d_convert_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .int_src(int_src),
    .wide_sel(wide_sel), .vec_src(vec_src), .glob_rm(glob_rm),
    .ovr_en(ovr_en), .ovr_rm(ovr_rm), .src_is_reg(src_is_reg),
    .out_valid(out_valid), .result(result), .inexact(inexact)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference model: right-shift based rounding from the requirement text
  function automatic logic [64:0] model(input logic [63:0] v, input logic [1:0] rm);
    int msb;
    int sh;
    logic [63:0] kept, rem, half;
    logic [10:0] e;
    logic [51:0] f;
    logic up, ix;
    if (v == 64'd0) return 65'd0;
    msb = 0;
    for (int i = 0; i < 64; i++) if (v[i]) msb = i;
    e = 11'(1023 + msb);
    ix = 1'b0;
    if (msb <= 52) begin
      kept = v << (52 - msb);
    end else begin
      sh   = msb - 52;
      kept = v >> sh;
      rem  = v & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      ix   = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || ((rem == half) && kept[0]);
        2'b10:   up = (rem != 0);
        default: up = 1'b0;
      endcase
      kept = kept + 64'(up);
      if (kept[53]) begin
        e    = e + 11'd1;
        kept = 64'd0;
      end
    end
    f = kept[51:0];
    return {ix, 1'b0, e, f};
  endfunction

  task automatic send(input logic [63:0] v, input bit wide, input logic [127:0] vec,
                      input logic [1:0] grm, input bit oen, input logic [1:0] orm,
                      input bit isreg, input string tag);
    logic [64:0] m;
    logic [1:0]  eff;
    logic [63:0] opnd;
    eff  = (isreg && oen && wide) ? orm : grm;
    opnd = wide ? v : {32'b0, v[31:0]};
    m    = model(opnd, eff);
    exp_lo_q.push_back(m[63:0]);
    exp_hi_q.push_back(vec[127:64]);
    exp_ix_q.push_back(m[64]);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; int_src = v; wide_sel = wide; vec_src = vec;
    glob_rm = grm; ovr_en = oen; ovr_rm = orm; src_is_reg = isreg;
    @(negedge clk);
    in_valid = 1'b0;
    int_src = ~v;
  endtask

  // Monitor: samples away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        if (exp_lo_q.size() == 0) begin
          check(1'b0, "R9 unexpected out_valid", 128'(out_valid), 128'd0);
        end else begin
          logic [63:0] elo, ehi;
          logic eix;
          string t;
          elo = exp_lo_q.pop_front();
          ehi = exp_hi_q.pop_front();
          eix = exp_ix_q.pop_front();
          t   = tag_q.pop_front();
          check(result[63:0] == elo, {t, " R2 R5 value"}, 128'(result[63:0]), 128'(elo));
          check(result[127:64] == ehi, {t, " R3 upper lane"}, 128'(result[127:64]), 128'(ehi));
          check(inexact == eix, {t, " R8 inexact"}, 128'(inexact), 128'(eix));
          check(result[MAXVL-1:128] == '0, {t, " R4 pad zero"},
                result[255:128], 128'd0);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] lfsr;
    logic [127:0] vv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 reset valid", 128'(out_valid), 128'd0);
    check(result == '0, "R10 reset result", result[127:0], 128'd0);
    check(inexact == 1'b0, "R10 reset inexact", 128'(inexact), 128'd0);

    vv = {64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444};
    send(64'd0, 1'b1, vv, 2'b00, 1'b0, 2'b00, 1'b1, "R2 zero64");
    send(64'hFFFF_FFFF_0000_0000, 1'b0, vv, 2'b10, 1'b0, 2'b00, 1'b0, "R1 R2 zero32 masked");
    send(64'd1, 1'b0, vv, 2'b00, 1'b0, 2'b00, 1'b0, "R2 one");
    send(64'hFFFF_FFFF_0000_0005, 1'b0, ~vv, 2'b00, 1'b0, 2'b00, 1'b1, "R1 masked upper");
    send(64'h0000_0000_FFFF_FFFF, 1'b0, vv, 2'b11, 1'b0, 2'b00, 1'b0, "R8 max32 exact");
    send(64'h0020_0000_0000_0001, 1'b1, vv, 2'b00, 1'b0, 2'b00, 1'b0, "R5 tie even down");
    send(64'h0020_0000_0000_0003, 1'b1, vv, 2'b00, 1'b0, 2'b00, 1'b0, "R5 tie even up");
    send(64'h0020_0000_0000_0001, 1'b1, vv, 2'b10, 1'b0, 2'b00, 1'b0, "R5 up");
    send(64'h0020_0000_0000_0001, 1'b1, vv, 2'b01, 1'b0, 2'b00, 1'b0, "R5 down");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, vv, 2'b00, 1'b0, 2'b00, 1'b0, "R5 max carry");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, vv, 2'b11, 1'b0, 2'b00, 1'b0, "R5 max trunc");
    send(64'h8000_0000_0000_0000, 1'b1, vv, 2'b10, 1'b0, 2'b00, 1'b0, "R2 top bit");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, vv, 2'b11, 1'b1, 2'b10, 1'b1, "R6 override reg");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, vv, 2'b11, 1'b1, 2'b10, 1'b0, "R6 memory global");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, vv, 2'b10, 1'b0, 2'b11, 1'b1, "R6 override off");
    send(64'h0000_0000_8765_4321, 1'b0, vv, 2'b00, 1'b1, 2'b10, 1'b1, "R7 narrow override a");
    send(64'h0000_0000_8765_4321, 1'b0, vv, 2'b00, 1'b1, 2'b11, 1'b1, "R7 narrow override b");

    // R9: idle gap then out_valid must drop
    @(negedge clk);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 idle valid", 128'(out_valid), 128'd0);

    lfsr = 64'hACE1_2345_6789_BEEF;
    for (int k = 0; k < 48; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      send(lfsr >> (k % 20), k[0], {lfsr, ~lfsr}, 2'(k), k[1], 2'(k >> 2),
           k[2], "R1 R5 R6 sweep");
    end

    repeat (4) @(negedge clk);
    check(exp_lo_q.size() == 0, "R9 drained", 128'(exp_lo_q.size()), 128'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule